// File: doc/BRIEF.md
# Guarded Watchdog Counter

This block is an up-counting watchdog. Its counter is as wide as the register bus. It advances on a one-cycle tick from an outside prescaler while the watchdog is running. When the counter wraps from all ones to zero, the block raises a reset request for one cycle and latches a trip flag. Software can read and reload the counter over a small register bus with an address bit, write data, a write strobe and read data. A control/status register sits beside it on the same bus.

Every state bit of the control register has a lock companion in the odd bit position just above it. A state bit changes only when its companion is written as 0 in the same access. The run bit and the trip-flag clear also need the register-write enable to be set already, before the access. The trip flag outlives the reset request the watchdog raises. After a restart, software can therefore tell that the watchdog caused it. Only the external reset pin clears all state.

Top module: `wdt_guard`

## Requirements
- R1: While `pin_rst_n` is low, the control register reads 0xAA, the counter reads 0x00 and `wdt_reset_req` is 0. After release, the watchdog does not count until it is enabled again.
- R2: When the run bit (control bit 2) is 1, each cycle with `tick` high adds one to the counter. When the run bit is 0, the counter holds its value.
- R3: A tick that moves the counter from 0xFF to 0x00 raises `wdt_reset_req` in the following cycle and sets the trip flag (control bit 0) at the same time.
- R4: `wdt_reset_req` stays high for exactly one cycle. The trip flag stays 1 after the pulse.
- R5: A control write (`bus_addr`=0) loads data bit 2 into the run bit only if data bit 3 is 0 and the register-write enable (control bit 4) was already 1 before the write.
- R6: A control write clears the trip flag only if data bits 1 and 0 are both 0 and control bit 4 was already 1. The bus can never set the trip flag.
- R7: Control bits 7, 5, 3 and 1 always read as 1.
- R8: Control bit 6 (counter-write enable) loads data bit 6 on any control write with data bit 7 at 0. Control bit 4 loads data bit 4 on any control write with data bit 5 at 0.
- R9: A counter write (`bus_addr`=1) loads the counter only when control bit 6 is 1. Otherwise the write has no effect.
- R10: A counter write that loads the counter takes priority over a tick in the same cycle.
- R11: A wrap sets the trip flag even when the same cycle carries a write that would clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| tick | input | 1 | One-cycle count enable from the prescaler |
| bus_addr | input | 1 | Register select: 0 control, 1 counter |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data of the selected register |
| wdt_reset_req | output | 1 | One-cycle reset request on wrap |

## Verification
The bench tries to turn on the run bit in the same write that sets the register-write enable. A design that used the new enable value would start counting one access too early. It pairs a counter load with a tick, where a wrong priority leaves the counter one higher than the loaded value. It also lines up a wrap with a flag-clear write, where a wrong priority loses the only record of the trip. Writes with each lock bit set must leave every register unchanged. The trip flag must survive the reset pulse, and a design that cleared it would hide the cause of the restart.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int REG_W  = 8;
  localparam int NPAIR  = REG_W / 2;
  localparam int B_FLAG      = 0;
  localparam int B_FLAG_LK   = 1;
  localparam int B_RUN       = 2;
  localparam int B_RUN_LK    = 3;
  localparam int B_CSRWE     = 4;
  localparam int B_CSRWE_LK  = 5;
  localparam int B_CNTWE     = 6;
  localparam int B_CNTWE_LK  = 7;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_CNT = 1'b1} sel_e;

  // a lock companion permits an update only when written as zero
  function automatic logic unlocked(input logic lock_bit);
    return lock_bit == 1'b0;
  endfunction
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         req_o
);
  function automatic logic [W:0] bump(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [W-1:0] cnt_q;
  logic         req_q;
  logic         step;
  logic [W:0]   nxt;

  always_comb begin
    step   = run_i && tick_i && !load_i;
    nxt    = bump(cnt_q);
    wrap_o = step && nxt[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= wrap_o;
      if (load_i)    cnt_q <= load_val_i;
      else if (step) cnt_q <= nxt[W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !load_i) |=> cnt_q == W'($past(cnt_q) + 1'b1));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(run_i && tick_i)) |=> $stable(cnt_q));
  assert_wrap_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (req_q && cnt_q == '0));
  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             wrap_i,
  output logic             run_o,
  output logic             cnt_we_o,
  output logic             flag_o,
  output logic [REG_W-1:0] rdata_o
);
  logic cnt_we_q, csr_we_q, run_q, flag_q;
  logic upd_cnt_we, upd_csr_we, upd_run, clr_flag;
  logic [NPAIR-1:0] state;

  always_comb begin
    upd_cnt_we = wr_i && unlocked(wdata_i[B_CNTWE_LK]);
    upd_csr_we = wr_i && unlocked(wdata_i[B_CSRWE_LK]);
    upd_run    = wr_i && unlocked(wdata_i[B_RUN_LK]) && csr_we_q;
    clr_flag   = wr_i && unlocked(wdata_i[B_FLAG_LK]) && csr_we_q && !wdata_i[B_FLAG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_we_q <= 1'b0;
      csr_we_q <= 1'b0;
      run_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (upd_cnt_we) cnt_we_q <= wdata_i[B_CNTWE];
      if (upd_csr_we) csr_we_q <= wdata_i[B_CSRWE];
      if (upd_run)    run_q    <= wdata_i[B_RUN];
      if (wrap_i)        flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  assign state = {cnt_we_q, csr_we_q, run_q, flag_q};

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    assign rdata_o[2*g]     = state[g];
    assign rdata_o[2*g + 1] = 1'b1;
  end

  assign run_o    = run_q;
  assign cnt_we_o = cnt_we_q;
  assign flag_o   = flag_q;

  assert_run_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && !wdata_i[B_RUN_LK] && csr_we_q) |=> $stable(run_q));
  assert_flag_noset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> !$rose(flag_q));
  assert_cnt_we_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && !wdata_i[B_CNTWE_LK]) |=> $stable(cnt_we_q));
  assert_csr_we_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && !wdata_i[B_CSRWE_LK]) |=> $stable(csr_we_q));
  assert_flag_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_q);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              pin_rst_n,
  input  logic              tick,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_reset_req
);
  logic              ctrl_wr, cnt_wr, cnt_load;
  logic              run, cnt_we, trip_flag, wrap_evt;
  logic [REG_W-1:0]  ctrl_rdata;
  logic [DATA_W-1:0] cnt_val;

  always_comb begin
    ctrl_wr  = bus_we && (sel_e'(bus_addr) == SEL_CTRL);
    cnt_wr   = bus_we && (sel_e'(bus_addr) == SEL_CNT);
    cnt_load = cnt_wr && cnt_we;
  end

  wdt_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (pin_rst_n),
    .wr_i     (ctrl_wr),
    .wdata_i  (bus_wdata[REG_W-1:0]),
    .wrap_i   (wrap_evt),
    .run_o    (run),
    .cnt_we_o (cnt_we),
    .flag_o   (trip_flag),
    .rdata_o  (ctrl_rdata)
  );

  wdt_count #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (pin_rst_n),
    .run_i      (run),
    .tick_i     (tick),
    .load_i     (cnt_load),
    .load_val_i (bus_wdata),
    .cnt_o      (cnt_val),
    .wrap_o     (wrap_evt),
    .req_o      (wdt_reset_req)
  );

  always_comb begin
    if (sel_e'(bus_addr) == SEL_CNT) bus_rdata = cnt_val;
    else                             bus_rdata = ctrl_rdata;
  end

  assert_req_flag_R3: assert property (@(posedge clk) disable iff (!pin_rst_n)
    wdt_reset_req |-> trip_flag);
  assert_cnt_lock_R9: assert property (@(posedge clk) disable iff (!pin_rst_n)
    (cnt_wr && !cnt_we && !(run && tick)) |=> $stable(cnt_val));
  assert_reset_idle_R1: assert property (@(posedge clk)
    !pin_rst_n |-> (!wdt_reset_req && !run));
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  logic       clk = 1'b0;
  logic       pin_rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       wdt_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_guard uut (
    .clk           (clk),
    .pin_rst_n     (pin_rst_n),
    .tick          (tick),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_we        (bus_we),
    .bus_rdata     (bus_rdata),
    .wdt_reset_req (wdt_reset_req)
  );

  typedef struct packed {
    logic       we;
    logic       addr;
    logic [7:0] data;
    logic       tk;
    logic [7:0] exp_ctrl;
    logic [7:0] exp_cnt;
    logic       exp_req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'hFF, 1'b0, 8'hAA, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'h14, 1'b0, 8'hBA, 8'h00, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'hBA, 8'h00, 1'b0},
    '{1'b1, 1'b1, 8'h55, 1'b0, 8'hBA, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'h14, 1'b0, 8'hBE, 8'h00, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'hBE, 8'h01, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b0, 8'hBE, 8'h01, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'hBE, 8'h02, 1'b0},
    '{1'b1, 1'b0, 8'h6A, 1'b0, 8'hFE, 8'h02, 1'b0},
    '{1'b1, 1'b1, 8'hFD, 1'b1, 8'hFE, 8'hFD, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'hFE, 8'hFE, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'hFE, 8'hFF, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'hFF, 8'h00, 1'b1},
    '{1'b0, 1'b0, 8'h00, 1'b0, 8'hFF, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'hAA, 1'b0, 8'hFF, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'hA8, 1'b0, 8'hFE, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'hA9, 1'b0, 8'hFE, 8'h00, 1'b0},
    '{1'b1, 1'b1, 8'hFF, 1'b0, 8'hFE, 8'hFF, 1'b0},
    '{1'b1, 1'b0, 8'hA8, 1'b1, 8'hFF, 8'h00, 1'b1},
    '{1'b1, 1'b0, 8'hA2, 1'b0, 8'hFB, 8'h00, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'hFB, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'h8A, 1'b0, 8'hEB, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'hA6, 1'b0, 8'hEB, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'hA8, 1'b0, 8'hEB, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'h2A, 1'b0, 8'hAB, 8'h00, 1'b0}
  };
  localparam string TAGS [NV] = '{
    "R8", "R8", "R2", "R9", "R5", "R2", "R2", "R2", "R8", "R10",
    "R2", "R2", "R3", "R4", "R6", "R6", "R6", "R9", "R11", "R5",
    "R2", "R8", "R5", "R6", "R8"
  };

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic a, input logic [7:0] d, input logic tk,
                      output logic [7:0] c, output logic [7:0] n, output logic r);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
    @(posedge clk);
    #2;
    bus_we = 1'b0; tick = 1'b0;
    r = wdt_reset_req;
    bus_addr = 1'b0; #1 c = bus_rdata;
    bus_addr = 1'b1; #1 n = bus_rdata;
  endtask

  task automatic peek(output logic [7:0] c, output logic [7:0] n, output logic r);
    r = wdt_reset_req;
    bus_addr = 1'b0; #1 c = bus_rdata;
    bus_addr = 1'b1; #1 n = bus_rdata;
  endtask

  initial begin
    logic [7:0] c, n;
    logic r;
    #5;
    peek(c, n, r);
    check("R1", "ctrl in reset", c, 8'hAA);
    check("R1", "count in reset", n, 8'h00);
    check("R1", "req in reset", {7'b0, r}, 8'h00);
    repeat (3) @(negedge clk);
    pin_rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].we, VECS[i].addr, VECS[i].data, VECS[i].tk, c, n, r);
      check(TAGS[i], "ctrl", c, VECS[i].exp_ctrl);
      check(TAGS[i], "count", n, VECS[i].exp_cnt);
      check(TAGS[i], "req", {7'b0, r}, {7'b0, VECS[i].exp_req});
      check("R7", "lock bits", c & 8'hAA, 8'hAA);
    end

    // directed: enable, run, then the reset pin clears all
    step(1'b1, 1'b0, 8'h9A, 1'b0, c, n, r);
    check("R8", "csr enable set", c, 8'hBB);
    step(1'b1, 1'b0, 8'hA6, 1'b0, c, n, r);
    check("R5", "run set", c, 8'hBF);
    step(1'b0, 1'b0, 8'h00, 1'b1, c, n, r);
    check("R2", "count after tick", n, 8'h01);
    @(negedge clk);
    pin_rst_n = 1'b0;
    #2;
    peek(c, n, r);
    check("R1", "ctrl after pin", c, 8'hAA);
    check("R1", "count after pin", n, 8'h00);
    check("R1", "req after pin", {7'b0, r}, 8'h00);
    @(negedge clk);
    pin_rst_n = 1'b1;
    step(1'b0, 1'b0, 8'h00, 1'b1, c, n, r);
    check("R1", "no count after pin", n, 8'h00);
    check("R1", "ctrl stays clear", c, 8'hAA);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule